// File: doc/BRIEF.md
# Fractional M/N Clock Enable Generator

This block turns a fixed reference clock into a train of one-cycle enable pulses whose average rate is a rational fraction M/N of the reference rate. It is meant to produce the 16x oversampling enable of a serial receiver/transmitter from a 100 MHz reference. The pulse generator is an accumulator that adds M every cycle. Whenever the sum reaches N, it takes N away and raises the enable for one cycle.

Software controls the block through one 32-bit register on a plain write/read port. A new ratio is first written with the run and commit bits clear. The same ratio is then written again with both bits set. Only the commit write copies M and N into the active ratio, and it also restarts the pulse phase from zero. When the block is stopped, or when either active value is zero, the output stays low.

Top module: `frac_tick_gen`

## Requirements
- R1: The control word has the run bit at bit 0, M in bits 15:1, N in bits 30:16 and the commit bit at bit 31. The run bit is stored on every write.
- R2: A write with bit 31 set loads the written M and N as the active ratio. A write with bit 31 clear leaves the active M and N and the running pulse phase unchanged.
- R3: A read returns the run bit at bit 0, the active M at bits 15:1 and the active N at bits 30:16. Bit 31 always reads 0.
- R4: While running with 0 < M <= N, step j (the j-th clock edge after the edge that accepted the commit or restart write) carries a pulse exactly when floor(j*M/N) differs from floor((j-1)*M/N). This gives M pulses in every N cycles.
- R5: A commit clears the accumulator. The output is low after the commit edge, and the pulse pattern restarts at step 1.
- R6: While the run bit is 0 the output is low and the accumulator is held at zero. Setting the run bit again restarts the pattern at step 1.
- R7: When the active M or the active N is zero, the output stays low.
- R8: An active M greater than N is treated as M = N, which gives a pulse on every cycle.
- R9: After reset the read value is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the control register this cycle |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Run bit and active ratio |
| tick | output | 1 | One-cycle enable pulse |

## Verification
Assertions check on every cycle that:
- the accumulator stays below N while running;
- a commit leaves the accumulator at zero with the output low;
- a stopped or zero-ratio generator emits nothing;
- M >= N gives a pulse on the next cycle;
- the active ratio changes only on a commit write, and then to the written fields.

Only the bench scenarios can show the exact pulse positions for many ratios. The same applies to how a write without commit leaves a running phase undisturbed, and to the readback layout.

// File: rtl/mn_clk_pkg.sv
// Shared widths and control-word bit positions for the M/N tick generator.
// Assumes 2*FRAC_W + 2 == REG_W so that every control bit has a meaning.
package mn_clk_pkg;
    localparam int REG_W   = 32;
    localparam int FRAC_W  = 15;
    localparam int RUN_BIT = 0;
    localparam int M_LSB   = 1;
    localparam int N_LSB   = M_LSB + FRAC_W;
    localparam int CMT_BIT = REG_W - 1;
endpackage

// File: rtl/mn_ctrl_reg.sv
// Control register: holds the run bit and the active M/N ratio.
// A write with the commit bit set copies the written M/N into the active
// ratio and raises commit_o in the same cycle so the accumulator restarts.
// Assumes the field layout of mn_clk_pkg; the commit bit is never stored.
module mn_ctrl_reg
    import mn_clk_pkg::*;
#(
    parameter int W = FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             run_o,
    output logic [W-1:0]     m_o,
    output logic [W-1:0]     n_o,
    output logic             commit_o,
    output logic [REG_W-1:0] rd_data_o
);
    logic         run_q;
    logic [W-1:0] m_q;
    logic [W-1:0] n_q;

    // Decode a commit request from the incoming write.
    always_comb commit_o = wr_en_i & wr_data_i[CMT_BIT];

    // Store the run bit on every write and the ratio on commit writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            m_q   <= '0;
            n_q   <= '0;
        end else if (wr_en_i) begin
            run_q <= wr_data_i[RUN_BIT];
            if (wr_data_i[CMT_BIT]) begin
                m_q <= wr_data_i[M_LSB +: W];
                n_q <= wr_data_i[N_LSB +: W];
            end
        end
    end

    // Assemble the readback word; the commit bit position reads as zero.
    always_comb begin
        rd_data_o              = '0;
        rd_data_o[RUN_BIT]     = run_q;
        rd_data_o[M_LSB +: W]  = m_q;
        rd_data_o[N_LSB +: W]  = n_q;
    end

    assign run_o = run_q;
    assign m_o   = m_q;
    assign n_o   = n_q;

    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_data_i[CMT_BIT]) |=> ($stable(m_q) && $stable(n_q)))
        else $error("active ratio changed without commit"); // R2
    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[CMT_BIT]) |=>
            (m_q == $past(wr_data_i[M_LSB +: W]) && n_q == $past(wr_data_i[N_LSB +: W])))
        else $error("commit did not load written ratio"); // R1
endmodule

// File: rtl/mn_accum.sv
// Accumulator pulse engine: adds M each cycle and emits a registered
// one-cycle tick whenever the sum reaches N, keeping the remainder.
// Assumes M and N change only together with clear_i. M > N is clamped to N.
module mn_accum #(
    parameter int W = mn_clk_pkg::FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] n_i,
    input  logic         clear_i,
    output logic         tick_o
);
    localparam int SUM_W = W + 1;

    logic [W-1:0]     acc_q;
    logic             tick_q;
    logic [W-1:0]     m_eff;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;
    logic             active;

    // Clamp the step, form the next sum and its wrapped value.
    always_comb begin
        active  = run_i && (m_i != '0) && (n_i != '0);
        m_eff   = (m_i > n_i) ? n_i : m_i;
        sum     = {1'b0, acc_q} + {1'b0, m_eff};
        wrapped = sum - {1'b0, n_i};
    end

    // Advance the phase, or hold it at zero when stopped or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !active) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (sum >= {1'b0, n_i}) begin
            acc_q  <= wrapped[W-1:0];
            tick_q <= 1'b1;
        end else begin
            acc_q  <= sum[W-1:0];
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (acc_q < n_i))
        else $error("accumulator escaped its range"); // R4
    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q == '0 && !tick_o))
        else $error("commit did not restart phase"); // R5
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!tick_o && acc_q == '0))
        else $error("tick while stopped"); // R6
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear_i && m_i >= n_i) |=> tick_o)
        else $error("missing pulse at full rate"); // R8
endmodule

// File: rtl/frac_tick_gen.sv
// Top of the fractional M/N clock enable generator: a control register
// feeding an accumulator pulse engine. Single clock domain and a
// synchronous active-low reset are assumed.
module frac_tick_gen
    import mn_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tick
);
    logic              run;
    logic              commit;
    logic [FRAC_W-1:0] m_act;
    logic [FRAC_W-1:0] n_act;

    mn_ctrl_reg #(.W(FRAC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .run_o     (run),
        .m_o       (m_act),
        .n_o       (n_act),
        .commit_o  (commit),
        .rd_data_o (rd_data)
    );

    mn_accum #(.W(FRAC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .m_i     (m_act),
        .n_i     (n_act),
        .clear_i (commit),
        .tick_o  (tick)
    );
endmodule

// File: tb/test_frac_tick_gen.sv
module test_frac_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    frac_tick_gen i_frac_tick_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
    );

    function automatic logic [31:0] word(bit en, int m, int n, bit cmt);
        return {cmt, n[14:0], m[14:0], en};
    endfunction

    function automatic logic [31:0] rd_exp(bit en, int m, int n);
        return {1'b0, n[14:0], m[14:0], en};
    endfunction

    function automatic bit exp_tick(int m, int n, int j);
        int e;
        if (m == 0 || n == 0) return 1'b0;
        e = (m > n) ? n : m;
        return ((j * e) / n) != (((j - 1) * e) / n);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge after the accepting edge.
    task automatic wr(logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Check steps first..last of the pattern for ratio m/n.
    task automatic run_steps(string req, int m, int n, int first, int last);
        for (int j = first; j <= last; j++) begin
            @(negedge clk);
            chk(req, {31'd0, tick}, {31'd0, exp_tick(m, n, j)});
        end
    endtask

    task automatic commit(int m, int n);
        wr(word(1'b0, m, n, 1'b0));
        wr(word(1'b1, m, n, 1'b1));
        chk("R5 tick low after commit", {31'd0, tick}, 32'd0);
        chk("R3 readback", rd_data, rd_exp(1'b1, m, n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R9 reset read", rd_data, 32'd0);
        chk("R9 reset tick", {31'd0, tick}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: layout and commit bit reads zero.
        commit(3, 10);
        chk("R3 bit31 zero", {31'd0, rd_data[31]}, 32'd0);
        run_steps("R4 3/10", 3, 10, 1, 25);

        // R2: write without commit keeps ratio and phase (edge is step 26).
        wr(word(1'b1, 7, 9, 1'b0));
        chk("R2 no-commit phase", {31'd0, tick}, {31'd0, exp_tick(3, 10, 26)});
        chk("R2 readback unchanged", rd_data, rd_exp(1'b1, 3, 10));
        run_steps("R2 old pattern", 3, 10, 27, 40);

        // R6: stop (edge still step 41), then low, then restart.
        wr(word(1'b0, 3, 10, 1'b0));
        chk("R6 stop edge", {31'd0, tick}, {31'd0, exp_tick(3, 10, 41)});
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R6 stopped low", {31'd0, tick}, 32'd0);
        end
        wr(word(1'b1, 3, 10, 1'b0));
        chk("R6 restart edge", {31'd0, tick}, 32'd0);
        run_steps("R6 restart pattern", 3, 10, 1, 20);

        // R5: commit mid-run restarts phase.
        commit(5, 7);
        run_steps("R5 restart 5/7", 5, 7, 1, 21);

        // R7: zero M and zero N.
        commit(0, 9);
        run_steps("R7 M zero", 0, 9, 1, 15);
        commit(4, 0);
        run_steps("R7 N zero", 4, 0, 1, 15);

        // R8: clamp and equal.
        commit(20, 6);
        run_steps("R8 clamp", 20, 6, 1, 12);
        commit(32767, 32767);
        run_steps("R8 full width equal", 32767, 32767, 1, 6);

        // R4: extreme small ratio.
        commit(1, 300);
        run_steps("R4 1/300", 1, 300, 1, 650);

        // R4 random ratios.
        for (int it = 0; it < 30; it++) begin
            int m = int'($urandom_range(1, 50));
            int n = int'($urandom_range(1, 50));
            commit(m, n);
            run_steps("R4 random", m, n, 1, 2 * n + 5);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule